// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine

This block takes a received Ethernet frame as a byte stream marked with start and end flags. It spreads that frame across a ring of receive descriptors held in word-addressed memory. For each descriptor it reads three words over a simple request/grant memory port: a control word, a length word and a buffer start address. It then stores frame bytes one at a time into that buffer until the frame ends or the buffer's length is used up. After that it writes the descriptor back and moves on to the next one. A frame can therefore fill several chained descriptors, and each of them can have a different buffer size.

Each write-back records how many bytes that buffer actually holds. It also records whether the buffer holds the first, a middle, the last or the only fragment of the frame, and it clears the ownership bit so that software can take the descriptor back. The descriptor stride is 16, 32 or 64 bytes. A descriptor flagged as the end of the list sends the engine back to the ring base. When the engine reaches a descriptor that software has not handed over, it raises an error pulse and discards the rest of the frame.

Top module: `rx_desc_scatter`

## Requirements
- R1: While reset is held and just after it is released, with no input offered, mem_req, frame_done and err_no_desc are all 0.
- R2: For each descriptor the engine reads the words at offsets 0, 4 and 8 from the descriptor address. The buffer length is taken from bits 31:16 of the word at offset 4, and the buffer byte address from the word at offset 8. A read request keeps its address until it is granted.
- R3: Frame bytes are stored in arrival order at consecutive byte addresses starting from the buffer address. No more than the buffer length is stored in one descriptor. Any remaining bytes continue in the following descriptors, in order.
- R4: The write-back of the word at offset 4 keeps the buffer length in bits 31:16 and puts in bits 15:0 the number of bytes stored in that buffer, not the frame total.
- R5: The write-back of the word at offset 0 has bit 31 (ownership) = 0 and keeps bit 30 (end of list). Bits 29:28 give the position: 2'b10 first fragment, 2'b00 middle, 2'b01 last, 2'b11 whole frame in one buffer. Bits 27:0 are 0. This word is written after the word at offset 4.
- R6: After a descriptor that does not end the list, the next descriptor address is the current one plus 16, 32 or 64 bytes for cfg_stride_sel = 0, 1 or 2; the value 3 selects 16.
- R7: After a descriptor whose bit 30 is set, the next descriptor address is cfg_ring_base. This base is captured at reset and must be 16-byte aligned.
- R8: If the word at offset 0 has bit 31 = 0, err_no_desc pulses for one cycle. Nothing is written to memory, the remaining bytes of the frame are accepted and dropped, and the descriptor pointer stays where it is, so the next frame tries the same descriptor again.
- R9: frame_done pulses high for exactly one cycle after the write-back of the descriptor that holds the frame's last byte.
- R10: Bytes offered while idle without in_sof are accepted and dropped, with no memory access and no change to the descriptor pointer.
- R11: Every memory write uses a word-aligned address. A buffer write enables only byte lane addr[1:0] and carries the byte in every lane. Descriptor write-backs enable all four lanes.
- R12: A 1514-byte frame sent into descriptors with 500-byte buffers leaves 500, 500, 500 and 14 bytes in four consecutive descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ring_base | input | AW | Byte address of the first descriptor of the ring |
| cfg_stride_sel | input | 2 | Descriptor stride select: 0 = 16, 1 = 32, 2 = 64 bytes |
| in_valid | input | 1 | A frame byte is offered |
| in_ready | output | 1 | The offered byte is taken this cycle |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | The offered byte is the first of a frame |
| in_eof | input | 1 | The offered byte is the last of a frame |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte-lane write enables |
| mem_gnt | input | 1 | The request completes this cycle |
| mem_rdata | input | 32 | Read data, valid while a read is granted |
| frame_done | output | 1 | One-cycle pulse after a frame's final write-back |
| err_no_desc | output | 1 | One-cycle pulse when a descriptor not owned by the engine is met |

## Verification
The bench sends frames whose length equals the buffer length exactly, or exceeds it by one byte. A design that compares the wrong count there either spills an empty fragment or leaves a stray byte, and shows the wrong position flags or data length. Frames that span three or more descriptors check the middle-fragment code, and the 1514-byte case against 500-byte buffers checks that the short tail lands in the fourth buffer. A wrap past the end-of-list descriptor and all three strides place descriptors at addresses the bench computes, so a wrong stride or a missed wrap leaves expected descriptors untouched. An unowned descriptor, stray bytes without a start flag and random grant stalls check that nothing is written when it should not be, that the engine retries the same descriptor, and that frame_done never stretches past one cycle.

// File: rtl/rxs_pkg.sv
`timescale 1ns/1ps
// Package: shared state type, descriptor field positions and stride decode
// for the receive descriptor scatter engine.
package rxs_pkg;
    localparam int WORD_W   = 32;
    localparam int LEN_W    = 16;
    localparam int OWN_BIT  = 31;
    localparam int LOL_BIT  = 30;
    localparam int FIRST_BIT = 29;
    localparam int LAST_BIT = 28;
    localparam int FLAG_PAD = 28;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_DATA, ST_WB1, ST_WB0, ST_DROP
    } rxs_state_e;

    // Descriptor stride in bytes for a 2-bit select; 3 falls back to 16.
    function automatic logic [6:0] stride_bytes(input logic [1:0] sel);
        case (sel)
            2'd1:    stride_bytes = 7'd32;
            2'd2:    stride_bytes = 7'd64;
            default: stride_bytes = 7'd16;
        endcase
    endfunction
endpackage

// File: rtl/rxs_ring_ptr.sv
`timescale 1ns/1ps
// Descriptor ring pointer. Holds the address of the current descriptor.
// It loads the ring base at reset, then steps by the configured stride or
// wraps to the base when the finished descriptor ended the list.
// Assumes the ring base is stable from reset onward.
module rxs_ring_ptr
    import rxs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic [1:0]    stride_sel,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] desc_addr
);
    // Move the pointer once per finished descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_addr <= base;
        end else if (advance) begin
            desc_addr <= wrap ? base : desc_addr + AW'(stride_bytes(stride_sel));
        end
    end
endmodule

// File: rtl/rxs_frag_track.sv
`timescale 1ns/1ps
// Fragment tracker. Captures one descriptor's buffer length and start
// address, then counts the bytes stored and advances the byte address.
// Assumes a nonzero buffer length and AW no wider than a memory word.
module rxs_frag_track
    import rxs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_len,
    input  logic              load_addr,
    input  logic              step,
    input  logic [WORD_W-1:0] rdata,
    output logic [LEN_W-1:0]  buf_len,
    output logic [LEN_W-1:0]  count,
    output logic [AW-1:0]     wr_addr,
    output logic              last_slot
);
    // Capture the descriptor fields and track progress through the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_len <= '0;
            count   <= '0;
            wr_addr <= '0;
        end else begin
            if (load_len) begin
                buf_len <= rdata[WORD_W-1 -: LEN_W];
                count   <= '0;
            end
            if (load_addr) wr_addr <= rdata[AW-1:0];
            if (step) begin
                count   <= count + 1'b1;
                wr_addr <= wr_addr + 1'b1;
            end
        end
    end

    // The byte being stored now takes the final free slot of the buffer.
    assign last_slot = (count == buf_len - 1'b1);
endmodule

// File: rtl/rxs_ctrl.sv
`timescale 1ns/1ps
// Sequencer for the scatter engine. It walks fetch, fill and write-back
// for each descriptor, keeps the fragment position flags, and raises the
// done and error pulses. Assumes memory completes a request on mem_gnt.
module rxs_ctrl
    import rxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       mem_gnt,
    input  logic       desc_active,
    input  logic       desc_lol,
    input  logic       last_slot,
    output rxs_state_e state,
    output logic       frag_first,
    output logic       frag_last,
    output logic       list_end,
    output logic       byte_take,
    output logic       desc_done,
    output logic       done_pulse,
    output logic       err_pulse
);
    // A byte is stored when the stream offers it and memory accepts it.
    assign byte_take = (state == ST_DATA) && in_valid && mem_gnt;
    // A descriptor is finished when its ownership word is written back.
    assign desc_done = (state == ST_WB0) && mem_gnt;

    // State transitions, fragment flags and pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            frag_first <= 1'b0;
            frag_last  <= 1'b0;
            list_end   <= 1'b0;
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
            case (state)
                ST_IDLE: if (in_valid && in_sof) begin
                    frag_first <= 1'b1;
                    state      <= ST_RD0;
                end
                ST_RD0: if (mem_gnt) begin
                    if (!desc_active) begin
                        err_pulse <= 1'b1;
                        state     <= ST_DROP;
                    end else begin
                        list_end <= desc_lol;
                        state    <= ST_RD1;
                    end
                end
                ST_RD1: if (mem_gnt) state <= ST_RD2;
                ST_RD2: if (mem_gnt) state <= ST_DATA;
                ST_DATA: if (byte_take) begin
                    if (in_eof) begin
                        frag_last <= 1'b1;
                        state     <= ST_WB1;
                    end else if (last_slot) begin
                        frag_last <= 1'b0;
                        state     <= ST_WB1;
                    end
                end
                ST_WB1: if (mem_gnt) state <= ST_WB0;
                ST_WB0: if (mem_gnt) begin
                    if (frag_last) begin
                        done_pulse <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        frag_first <= 1'b0;
                        state      <= ST_RD0;
                    end
                end
                ST_DROP: if (in_valid && in_eof) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_desc_scatter.sv
`timescale 1ns/1ps
// Receive descriptor scatter engine, top level. It joins the sequencer,
// the fragment tracker and the ring pointer, and builds the memory request
// for the current state. Assumes 32-bit memory words, a 16-byte aligned
// ring base, and a stream source that holds each byte until it is taken.
module rx_desc_scatter
    import rxs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_ring_base,
    input  logic [1:0]        cfg_stride_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              frame_done,
    output logic              err_no_desc
);
    rxs_state_e       state;
    logic             frag_first, frag_last, list_end;
    logic             byte_take, desc_done, last_slot;
    logic [LEN_W-1:0] buf_len, count;
    logic [AW-1:0]    wr_addr, desc_addr;

    rxs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .mem_gnt    (mem_gnt),
        .desc_active(mem_rdata[OWN_BIT]),
        .desc_lol   (mem_rdata[LOL_BIT]),
        .last_slot  (last_slot),
        .state      (state),
        .frag_first (frag_first),
        .frag_last  (frag_last),
        .list_end   (list_end),
        .byte_take  (byte_take),
        .desc_done  (desc_done),
        .done_pulse (frame_done),
        .err_pulse  (err_no_desc)
    );

    rxs_frag_track #(.AW(AW)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_len ((state == ST_RD1) && mem_gnt),
        .load_addr((state == ST_RD2) && mem_gnt),
        .step     (byte_take),
        .rdata    (mem_rdata),
        .buf_len  (buf_len),
        .count    (count),
        .wr_addr  (wr_addr),
        .last_slot(last_slot)
    );

    rxs_ring_ptr #(.AW(AW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .base      (cfg_ring_base),
        .stride_sel(cfg_stride_sel),
        .advance   (desc_done),
        .wrap      (list_end),
        .desc_addr (desc_addr)
    );

    // Stream acceptance: drop while idle or discarding, store while filling.
    always_comb begin
        case (state)
            ST_IDLE: in_ready = !in_sof;
            ST_DROP: in_ready = 1'b1;
            ST_DATA: in_ready = mem_gnt;
            default: in_ready = 1'b0;
        endcase
    end

    // Memory request for descriptor reads, byte stores and write-backs.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        mem_wstrb = 4'h0;
        case (state)
            ST_RD0: mem_req = 1'b1;
            ST_RD1: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(4);
            end
            ST_RD2: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(8);
            end
            ST_DATA: begin
                mem_req   = in_valid;
                mem_we    = 1'b1;
                mem_addr  = {wr_addr[AW-1:2], 2'b00};
                mem_wdata = {4{in_data}};
                mem_wstrb = 4'b0001 << wr_addr[1:0];
            end
            ST_WB1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(4);
                mem_wdata = {buf_len, count};
                mem_wstrb = 4'hF;
            end
            ST_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {1'b0, list_end, frag_first, frag_last, FLAG_PAD'(0)};
                mem_wstrb = 4'hF;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxs_checker.sv
`timescale 1ns/1ps
// Protocol checker for the scatter engine, attached to the top by bind.
// It watches only the memory port and the pulse outputs.
module rxs_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic [3:0]    mem_wstrb,
    input logic          frame_done,
    input logic          err_no_desc
);
    // R2: a pending descriptor read keeps its address until granted.
    assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !mem_gnt) |=> (mem_req && !mem_we && $stable(mem_addr)));

    // R11: writes are word aligned and enable one lane or all four.
    assert_write_lanes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[1:0] == 2'b00 &&
            ($countones(mem_wstrb) == 1 || mem_wstrb == 4'hF)));

    // R5: a full-word write to a control word always releases ownership.
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wstrb == 4'hF && mem_addr[3:2] == 2'b00) |-> !mem_wdata[31]);

    // R9: the done pulse lasts one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8: the error pulse lasts one cycle and never coincides with a write.
    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_no_desc |-> (!frame_done && !(mem_req && mem_we)));

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_no_desc |=> !err_no_desc);
endmodule

bind rx_desc_scatter rxs_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_wstrb  (mem_wstrb),
    .frame_done (frame_done),
    .err_no_desc(err_no_desc)
);

// File: tb/rx_desc_scatter_tb.sv
`timescale 1ns/1ps
module rx_desc_scatter_tb;
    localparam int AW = 32;
    localparam int NDESC = 8;
    localparam logic [31:0] RING_BASE = 32'h100;
    localparam logic [31:0] BUF_BASE = 32'h1000;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] cfg_ring_base = RING_BASE;
    logic [1:0] cfg_stride_sel = 2'd0;
    logic in_valid = 0, in_sof = 0, in_eof = 0, in_ready;
    logic [7:0] in_data = 0;
    logic mem_req, mem_we, mem_gnt = 0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [3:0] mem_wstrb;
    logic frame_done, err_no_desc;

    logic [31:0] mem [0:8191];
    logic hw_en = 0;
    logic [31:0] hw_addr = 0, hw_data = 0;
    int wr_cnt = 0, done_cnt = 0, err_cnt = 0;
    int checks = 0, fails = 0;
    bit finished = 0;
    int blen [NDESC];
    bit lolb [NDESC];
    int exp_idx = 0;

    always #10 clk = ~clk;

    rx_desc_scatter #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base),
        .cfg_stride_sel(cfg_stride_sel), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wstrb(mem_wstrb), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .frame_done(frame_done), .err_no_desc(err_no_desc)
    );

    assign mem_rdata = mem[mem_addr[14:2]];

    // Memory model, host writes and pulse counters.
    always @(posedge clk) begin
        if (hw_en) mem[hw_addr[14:2]] <= hw_data;
        if (rst_n && mem_req && mem_gnt && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_wstrb[b]) mem[mem_addr[14:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            wr_cnt <= wr_cnt + 1;
        end
        if (rst_n && frame_done) done_cnt <= done_cnt + 1;
        if (rst_n && err_no_desc) err_cnt <= err_cnt + 1;
    end

    // Random grant stalls.
    always @(negedge clk) mem_gnt <= ($urandom % 4) != 0;

    function automatic logic [7:0] pat(int fid, int i);
        return 8'((i * 7) ^ (fid * 29) ^ (i >> 8));
    endfunction
    function automatic int stride(logic [1:0] s);
        return (s == 2'd1) ? 32 : (s == 2'd2) ? 64 : 16;
    endfunction
    function automatic logic [31:0] daddr(int idx);
        return RING_BASE + 32'(idx * stride(cfg_stride_sel));
    endfunction
    function automatic logic [31:0] baddr(int idx);
        return BUF_BASE + 32'(idx * 32'h800);
    endfunction
    function automatic logic [31:0] rdw(logic [31:0] a);
        return mem[a[14:2]];
    endfunction
    function automatic logic [7:0] rdb(logic [31:0] a);
        logic [31:0] w;
        w = mem[a[14:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic put_word(logic [31:0] a, logic [31:0] v);
        @(negedge clk);
        hw_addr = a; hw_data = v; hw_en = 1;
        @(negedge clk);
        hw_en = 0;
    endtask

    task automatic arm(int idx, int len, bit lol, bit active);
        blen[idx] = len;
        lolb[idx] = lol;
        put_word(daddr(idx) + 4, {16'(len), 16'h0});
        put_word(daddr(idx) + 8, baddr(idx));
        put_word(daddr(idx), {active, lol, 30'h0});
    endtask

    task automatic arm_ring(int n, int lo, int hi);
        for (int i = 0; i < n; i++)
            arm(i, (lo == hi) ? lo : lo + int'($urandom % (hi - lo + 1)), i == n - 1, 1'b1);
    endtask

    task automatic do_reset(logic [1:0] s);
        @(negedge clk);
        rst_n = 0; cfg_stride_sel = s;
        repeat (3) @(negedge clk);
        chk(mem_req == 0 && frame_done == 0 && err_no_desc == 0, "R1 outputs in reset",
            {mem_req, frame_done, err_no_desc}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(mem_req == 0 && frame_done == 0 && err_no_desc == 0, "R1 outputs after reset",
            {mem_req, frame_done, err_no_desc}, 0);
        exp_idx = 0;
    endtask

    task automatic send_frame(int len, int fid, bit with_sof);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1; in_data = pat(fid, i);
            in_sof = with_sof && (i == 0); in_eof = (i == len - 1);
            forever begin
                #8;
                if (in_ready) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
    endtask

    task automatic wait_end(int d0);
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk);
            if (done_cnt != d0) break;
        end
        repeat (3) @(negedge clk);
        chk(done_cnt == d0 + 1, "R9 one done pulse per frame", done_cnt - d0, 1);
    endtask

    task automatic check_frame(int len, int fid);
        int rem, idx, off, n, bad;
        bit first, last;
        logic [31:0] w0, w1, e0;
        rem = len; idx = exp_idx; off = 0; first = 1;
        while (rem > 0) begin
            n = (rem < blen[idx]) ? rem : blen[idx];
            last = (rem == n);
            w1 = rdw(daddr(idx) + 4);
            w0 = rdw(daddr(idx));
            chk(w1[15:0] == 16'(n), "R4 stored length", w1[15:0], n);
            chk(w1[31:16] == 16'(blen[idx]), "R4 buffer length kept", w1[31:16], blen[idx]);
            e0 = {1'b0, lolb[idx], first, last, 28'h0};
            chk(w0 == e0, "R5 R6 control word at stride-placed descriptor", w0, e0);
            bad = 0;
            for (int k = 0; k < n; k++)
                if (rdb(baddr(idx) + 32'(k)) != pat(fid, off + k)) bad++;
            chk(bad == 0, "R3 buffer bytes", bad, 0);
            off += n; rem -= n; first = 0;
            idx = lolb[idx] ? 0 : idx + 1;
        end
        exp_idx = idx;
    endtask

    task automatic run_frame(int len, int fid);
        int d0;
        d0 = done_cnt;
        send_frame(len, fid, 1'b1);
        wait_end(d0);
        check_frame(len, fid);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int w0, e0, d0, fid, len;
        void'($urandom(32'd4242));

        // R12, R7: 1514-byte frame over four 500-byte buffers, then wrap.
        do_reset(2'd0);
        for (int i = 0; i < 4; i++) arm(i, 500, i == 3, 1'b1);
        run_frame(1514, 1);
        chk(rdw(daddr(3) + 4) == {16'd500, 16'd14}, "R12 fourth buffer holds 14",
            rdw(daddr(3) + 4), {16'd500, 16'd14});
        chk(exp_idx == 0, "R7 ring wraps after end of list", exp_idx, 0);
        for (int i = 0; i < 4; i++) arm(i, 500, i == 3, 1'b1);
        run_frame(60, 2);
        chk(rdw(daddr(0) + 4) == {16'd500, 16'd60}, "R7 wrapped frame in first descriptor",
            rdw(daddr(0) + 4), {16'd500, 16'd60});

        // R5, R6: stride 32, exact fit, one over, three fragments.
        do_reset(2'd1);
        arm_ring(NDESC, 100, 100);
        run_frame(100, 3);
        run_frame(101, 4);
        run_frame(250, 5);
        chk(exp_idx == 6, "R6 pointer after six descriptors", exp_idx, 6);

        // R8: unowned descriptor at stride 64.
        do_reset(2'd2);
        arm_ring(NDESC, 64, 64);
        arm(0, 64, 1'b0, 1'b0);
        w0 = wr_cnt; e0 = err_cnt; d0 = done_cnt;
        send_frame(40, 6, 1'b1);
        repeat (5) @(negedge clk);
        chk(err_cnt == e0 + 1, "R8 error pulse", err_cnt - e0, 1);
        chk(wr_cnt == w0, "R8 no memory writes", wr_cnt - w0, 0);
        chk(done_cnt == d0, "R8 no done pulse", done_cnt - d0, 0);
        chk(rdw(daddr(0)) == 32'h0, "R8 descriptor left as is", rdw(daddr(0)), 0);
        arm(0, 64, 1'b0, 1'b1);
        run_frame(40, 7);

        // R10: bytes without a start flag while idle.
        w0 = wr_cnt; d0 = done_cnt;
        send_frame(10, 8, 1'b0);
        repeat (10) @(negedge clk);
        chk(wr_cnt == w0, "R10 stray bytes not stored", wr_cnt - w0, 0);
        chk(done_cnt == d0, "R10 stray bytes no done", done_cnt - d0, 0);
        run_frame(30, 9);
        chk(exp_idx == 2, "R10 pointer unchanged by stray bytes", exp_idx, 2);

        // R2 R3 R4 R11: random lengths and buffer sizes at every stride.
        fid = 20;
        for (int s = 0; s < 3; s++) begin
            do_reset(2'(s));
            for (int f = 0; f < 5; f++) begin
                arm_ring(NDESC, 200, 600);
                len = 1 + int'($urandom % 1600);
                run_frame(len, fid);
                fid++;
            end
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule